// File: doc/BRIEF.md
# Two-Policy Set-Associative Data Cache Controller

This controller sits between a processor port that issues one 32-bit word access at a time and a memory port that transfers a whole 32-byte line, or a single masked word. A flag that travels with each access picks how that access is handled. In copy-back mode a write that misses first brings the line into the cache and then merges the word, so the line becomes modified. In pass-through mode a write that misses goes straight to memory and no line is allocated. A read that misses loads a line in either mode.

The storage is organised as two ways of sixteen sets, with 32-byte lines. Each line has its own valid bit and modified bit. When a set has an empty way, that way is filled first. When both ways hold data, a free-running 16-bit LFSR picks the way to replace. A modified victim is written out in full before its slot is refilled. While a miss or a memory write is in progress, the processor port holds its ready signal low. Each completed access ends with a one-cycle response pulse.

Top module: `dcache_ctrl`

## Requirements
- R1: Reset clears every valid and modified bit. After reset `cpuReady` is high, `cpuRespValid` and `memReq` are low, and the first read to any address fetches a line from memory.
- R2: A read hit returns the addressed word with no memory transaction. `cpuRespValid` is high for exactly one cycle, starting at the first rising edge after the edge that accepts the request.
- R3: A read miss issues one line read and returns the addressed word. `cpuReady` stays low for as long as `memReq` is high, and `memReq`, `memWe` and `memAddr` hold steady until `memAck`.
- R4: A copy-back write miss (`cpuWb`=1) refills the line, merges the written word, marks the line modified and writes nothing to memory. A later read of that word hits and returns the new value.
- R5: A copy-back write hit changes only the cache. No memory transaction takes place, and memory keeps its old value.
- R6: A pass-through write miss (`cpuWb`=0) makes exactly one word write with `memWordEn` one-hot at bit `cpuAddr[4:2]`, and no line read. Because the line is not allocated, a later read of that address misses.
- R7: A pass-through write hit updates both the cached word and memory. The line stays unmodified and is never written back.
- R8: A modified victim is written back as a full line (`memWordEn`=8'hFF, `memAddr[4:0]`=0) holding its current data, before the refill read. An unmodified victim is never written back.
- R9: On a miss, an invalid way of the set is filled before any valid way is replaced. The LFSR chooses the way only when both ways are valid.
- R10: The address splits into a tag `[31:9]`, a set index `[8:5]` and a word select `[4:2]`. The address of a line transaction is the request or victim address with bits `[4:0]` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Access request, accepted while cpuReady is high |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWb | input | 1 | Policy flag: 1 = copy-back with allocate on write, 0 = pass-through without allocate |
| cpuAddr | input | 32 | Byte address of the word |
| cpuWdata | input | 32 | Write data |
| cpuReady | output | 1 | Controller idle and able to take a request |
| cpuRespValid | output | 1 | One-cycle completion pulse |
| cpuRdata | output | 32 | Read data, valid with cpuRespValid |
| memReq | output | 1 | Memory transaction request, held until memAck |
| memWe | output | 1 | 1 = memory write, 0 = line read |
| memAddr | output | 32 | Byte address, line aligned for line transfers |
| memWline | output | 256 | Write data, word k in bits [32k+31:32k] |
| memWordEn | output | 8 | Word enables for writes: all ones for a line, one-hot for a word |
| memRline | input | 256 | Line read data |
| memAck | input | 1 | One-cycle completion of a memory transaction |

## Verification
A read hit produces its response one rising edge after the accepting edge. The bench records the cycle count on the falling edge after acceptance and requires exactly one more edge when the response pulse is sampled. A miss is complete only after one line transaction, or two when a modified victim must go out first, and each of these waits for the model memory's fixed latency. So every response is compared by a scoreboard at the falling edge where it appears, not at a fixed delay. Memory-side effects are counted by the memory model at the moment it performs a transaction: line reads, line writes, word writes and the word enable. Each access compares these counts before and after, which makes "no traffic" and "exactly one write" checkable.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_WRITETHRU,
    ST_RESPOND
  } ctrlState_t;

  typedef enum logic [1:0] {
    SEL_VICTIM,
    SEL_LINE,
    SEL_WORD
  } memSel_t;

  typedef struct packed {
    logic    latchReq;
    logic    capture;
    logic    hitWrite;
    logic    refillWrite;
    memSel_t memSel;
  } ctrlStrobe_t;

  typedef struct packed {
    logic hit;
    logic victimDirty;
    logic reqWe;
    logic reqWb;
  } dpStatus_t;

endpackage

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  output dpStatus_t                    status,
  input  logic                         cpuWe,
  input  logic                         cpuWb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic [WORD_W-1:0]            respData,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [WORD_W*LINE_WORDS-1:0] memWline,
  output logic [LINE_WORDS-1:0]        memWordEn,
  input  logic [WORD_W*LINE_WORDS-1:0] memRline
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int LFSR_W = 16;

  // Latched request
  logic [ADDR_W-1:BYTE_W] reqAddr;
  logic [WORD_W-1:0]      reqWdata;
  logic                   reqWe, reqWb;

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWord;

  assign reqTag  = reqAddr[ADDR_W-1:OFF_W+IDX_W];
  assign reqIdx  = reqAddr[OFF_W+IDX_W-1:OFF_W];
  assign reqWord = reqAddr[OFF_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      reqWb    <= 1'b0;
    end else if (strobe.latchReq) begin
      reqAddr  <= cpuAddr[ADDR_W-1:BYTE_W];
      reqWdata <= cpuWdata;
      reqWe    <= cpuWe;
      reqWb    <= cpuWb;
    end
  end

  // Storage
  logic [TAG_W-1:0]  tagArr   [WAYS][SETS];
  logic [LINE_W-1:0] dataArr  [WAYS][SETS];
  logic [SETS-1:0]   validArr [WAYS];
  logic [SETS-1:0]   dirtyArr [WAYS];

  // Tag compare, one comparator per way
  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] setValid;
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign setValid[w] = validArr[w][reqIdx];
    assign hitVec[w]   = setValid[w] && (tagArr[w][reqIdx] == reqTag);
  end

  logic [WAY_W-1:0] hitWay;
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
    end
  end

  // Replacement: lowest invalid way, else pseudo-random
  logic [LFSR_W-1:0] lfsr;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= 16'hACE1;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  logic [WAY_W-1:0] victimWay;
  logic             freeFound;
  always_comb begin
    victimWay = lfsr[WAY_W-1:0];
    freeFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!freeFound && !setValid[w]) begin
        victimWay = WAY_W'(w);
        freeFound = 1'b1;
      end
    end
  end

  assign status.hit         = |hitVec;
  assign status.victimDirty = validArr[victimWay][reqIdx] && dirtyArr[victimWay][reqIdx];
  assign status.reqWe       = reqWe;
  assign status.reqWb       = reqWb;

  logic [WAY_W-1:0] victimWayR;

  // Refill data with the written word merged in
  logic [LINE_W-1:0] refillLine;
  always_comb begin
    refillLine = memRline;
    if (reqWe) refillLine[int'(reqWord)*WORD_W +: WORD_W] = reqWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      victimWayR <= '0;
      respData   <= '0;
    end else begin
      if (strobe.capture) begin
        victimWayR <= victimWay;
        respData   <= dataArr[hitWay][reqIdx][int'(reqWord)*WORD_W +: WORD_W];
      end
      if (strobe.refillWrite) respData <= refillLine[int'(reqWord)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.hitWrite) dataArr[hitWay][reqIdx][int'(reqWord)*WORD_W +: WORD_W] <= reqWdata;
    if (strobe.refillWrite) begin
      dataArr[victimWayR][reqIdx] <= refillLine;
      tagArr[victimWayR][reqIdx]  <= reqTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        validArr[w] <= '0;
        dirtyArr[w] <= '0;
      end
    end else begin
      if (strobe.hitWrite && reqWb) dirtyArr[hitWay][reqIdx] <= 1'b1;
      if (strobe.refillWrite) begin
        validArr[victimWayR][reqIdx] <= 1'b1;
        dirtyArr[victimWayR][reqIdx] <= reqWe;
      end
    end
  end

  // Memory-side address and data selection
  always_comb begin
    case (strobe.memSel)
      SEL_VICTIM: begin
        memAddr   = {tagArr[victimWayR][reqIdx], reqIdx, OFF_W'(0)};
        memWline  = dataArr[victimWayR][reqIdx];
        memWordEn = '1;
      end
      SEL_WORD: begin
        memAddr   = {reqAddr, BYTE_W'(0)};
        memWline  = {LINE_WORDS{reqWdata}};
        memWordEn = LINE_WORDS'(1) << reqWord;
      end
      default: begin
        memAddr   = {reqTag, reqIdx, OFF_W'(0)};
        memWline  = {LINE_WORDS{reqWdata}};
        memWordEn = '1;
      end
    endcase
  end

  // R4: a refill leaves the line valid, modified only for an allocating write
  p_refill_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refillWrite |=> validArr[victimWayR][reqIdx] && (dirtyArr[victimWayR][reqIdx] == reqWe));

  // R7: a pass-through write hit on a clean line leaves it clean
  p_wt_hit_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.hitWrite && !reqWb && !dirtyArr[hitWay][reqIdx]) |=> !dirtyArr[hitWay][reqIdx]);

  // R9: with a free way in the set, the refill goes into a free way
  p_prefer_invalid_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !status.hit && !(&setValid)) |=> !validArr[victimWayR][reqIdx]);

endmodule

// File: rtl/dcache_fsm.sv
module dcache_fsm
  import dcache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  dpStatus_t   status,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        cpuReady,
  output logic        cpuRespValid,
  output logic        memReq,
  output logic        memWe
);

  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState     = state;
    strobe        = '0;
    strobe.memSel = SEL_LINE;
    memReq        = 1'b0;
    memWe         = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          strobe.latchReq = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strobe.capture = 1'b1;
        if (status.hit) begin
          if (status.reqWe) begin
            strobe.hitWrite = 1'b1;
            nextState       = status.reqWb ? ST_RESPOND : ST_WRITETHRU;
          end else begin
            nextState = ST_RESPOND;
          end
        end else if (status.reqWe && !status.reqWb) begin
          nextState = ST_WRITETHRU;
        end else begin
          nextState = status.victimDirty ? ST_WRITEBACK : ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_VICTIM;
        if (memAck) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        memReq        = 1'b1;
        strobe.memSel = SEL_LINE;
        if (memAck) begin
          strobe.refillWrite = 1'b1;
          nextState          = ST_RESPOND;
        end
      end
      ST_WRITETHRU: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        strobe.memSel = SEL_WORD;
        if (memAck) nextState = ST_RESPOND;
      end
      ST_RESPOND: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign cpuReady     = (state == ST_IDLE);
  assign cpuRespValid = (state == ST_RESPOND);

  // R3: the processor port is blocked while memory is busy
  p_ready_blocked_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  // R2: the response is a single-cycle pulse, then the port reopens
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |=> !cpuRespValid && cpuReady);

  // R6: a pass-through write miss goes to memory without a refill
  p_wt_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && !status.hit && status.reqWe && !status.reqWb) |=> (memReq && memWe));

  // R8: a modified victim is written out before the refill
  p_wb_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITEBACK && memAck) |=> (memReq && !memWe));

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuReq,
  input  logic                         cpuWe,
  input  logic                         cpuWb,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic [WORD_W-1:0]            cpuWdata,
  output logic                         cpuReady,
  output logic                         cpuRespValid,
  output logic [WORD_W-1:0]            cpuRdata,
  output logic                         memReq,
  output logic                         memWe,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [WORD_W*LINE_WORDS-1:0] memWline,
  output logic [LINE_WORDS-1:0]        memWordEn,
  input  logic [WORD_W*LINE_WORDS-1:0] memRline,
  input  logic                         memAck
);

  localparam int OFF_W = $clog2(LINE_WORDS) + $clog2(WORD_W / 8);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  dcache_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReq       (cpuReq),
    .status       (status),
    .memAck       (memAck),
    .strobe       (strobe),
    .cpuReady     (cpuReady),
    .cpuRespValid (cpuRespValid),
    .memReq       (memReq),
    .memWe        (memWe)
  );

  dcache_datapath #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .LINE_WORDS (LINE_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .status    (status),
    .cpuWe     (cpuWe),
    .cpuWb     (cpuWb),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .respData  (cpuRdata),
    .memAddr   (memAddr),
    .memWline  (memWline),
    .memWordEn (memWordEn),
    .memRline  (memRline)
  );

  // R3: a memory request and its attributes hold until acknowledged
  p_req_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq && $stable(memAddr) && $stable(memWe));

  // R8 / R10: line transfers are line aligned
  p_line_aligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && (&memWordEn)) |-> (memAddr[OFF_W-1:0] == '0));

  // R6: a single-word write enables exactly one word
  p_word_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !(&memWordEn)) |-> ($countones(memWordEn) == 1));

endmodule

// File: tb/test_dcache_ctrl.sv
module test_dcache_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int MEM_WORDS  = 4096;
  localparam int LINES      = MEM_WORDS / 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0, cpuWb = 1'b0;
  logic [31:0]  cpuAddr = '0, cpuWdata = '0;
  logic         cpuReady, cpuRespValid;
  logic [31:0]  cpuRdata;
  logic         memReq, memWe;
  logic [31:0]  memAddr;
  logic [255:0] memWline;
  logic [7:0]   memWordEn;
  logic [255:0] memRline = '0;
  logic         memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcache_ctrl i_dcache_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuWb(cpuWb),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuReady(cpuReady),
    .cpuRespValid(cpuRespValid), .cpuRdata(cpuRdata), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWline(memWline),
    .memWordEn(memWordEn), .memRline(memRline), .memAck(memAck)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Memory model, architectural reference and modified-line tracking
  logic [31:0] mem  [MEM_WORDS];
  logic [31:0] arch [MEM_WORDS];
  bit          dirtyLine [LINES];
  int lineReads = 0, lineWrites = 0, wordWrites = 0;
  logic [7:0]  lastWordEn = '0;
  logic [31:0] lastLineAddr = '0;
  bit          busy = 1'b0;
  int          cnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; memAck <= 1'b0; cnt <= 0;
    end else if (memAck) begin
      memAck <= 1'b0; busy <= 1'b0;
    end else if (!busy && memReq) begin
      busy <= 1'b1; cnt <= LAT;
      chk(!cpuReady, "R3", "cpuReady during memory access", 32'(cpuReady), 0);
    end else if (busy) begin
      if (cnt == 0) begin
        int base;
        base = int'(memAddr[13:5]) * 8;
        if (memWe && (&memWordEn)) begin
          lineWrites++;
          chk(dirtyLine[memAddr[13:5]], "R8", "writeback of unmodified line", memAddr, 0);
          chk(memAddr[4:0] == 0, "R8", "writeback alignment", memAddr, {memAddr[31:5], 5'b0});
          for (int k = 0; k < 8; k++) begin
            chk(memWline[k*32 +: 32] == arch[base+k], "R8", "writeback data",
                memWline[k*32 +: 32], arch[base+k]);
            mem[base+k] = memWline[k*32 +: 32];
          end
          dirtyLine[memAddr[13:5]] = 1'b0;
        end else if (memWe) begin
          wordWrites++;
          lastWordEn = memWordEn;
          for (int k = 0; k < 8; k++)
            if (memWordEn[k]) mem[base+k] = memWline[k*32 +: 32];
        end else begin
          logic [255:0] ln;
          lineReads++;
          lastLineAddr = memAddr;
          for (int k = 0; k < 8; k++) ln[k*32 +: 32] = mem[base+k];
          memRline <= ln;
        end
        memAck <= 1'b1;
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard
  typedef struct {
    bit          isRead;
    logic [31:0] data;
    logic [31:0] addr;
  } item_t;
  item_t q[$];
  item_t got;
  int respCount = 0, acceptCyc = 0, lastLat = 0;

  always @(negedge clk) begin
    if (rstN && cpuRespValid) begin
      lastLat = cyc - acceptCyc;
      if (q.size() == 0) begin
        chk(1'b0, "R2", "response with nothing pending", 1, 0);
      end else begin
        got = q.pop_front();
        if (got.isRead)
          chk(cpuRdata == got.data, "R3", $sformatf("read data @%h", got.addr), cpuRdata, got.data);
      end
      respCount++;
    end
  end

  task automatic access(input logic [31:0] a, input bit we, input bit wb, input logic [31:0] d);
    item_t it;
    int prev;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuWb = wb; cpuAddr = a; cpuWdata = d;
    it.isRead = !we; it.data = arch[a[13:2]]; it.addr = a;
    if (we) begin
      arch[a[13:2]] = d;
      if (wb) dirtyLine[a[13:5]] = 1'b1;
    end
    q.push_back(it);
    prev = respCount;
    @(posedge clk);
    @(negedge clk);
    cpuReq = 1'b0;
    acceptCyc = cyc;
    while (respCount == prev) @(negedge clk);
  endtask

  int r0, w0, ww0;
  task automatic snap();
    r0 = lineReads; w0 = lineWrites; ww0 = wordWrites;
  endtask

  task automatic noTraffic(input string req);
    chk(lineReads == r0 && lineWrites == w0 && wordWrites == ww0, req, "unexpected memory traffic",
        32'(lineReads - r0 + lineWrites - w0 + wordWrites - ww0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) begin
      mem[i]  = 32'hA500_0000 ^ (i * 32'h0001_0203);
      arch[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) dirtyLine[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(cpuReady == 1'b1, "R1", "cpuReady after reset", 32'(cpuReady), 1);
    chk(cpuRespValid == 1'b0, "R1", "cpuRespValid after reset", 32'(cpuRespValid), 0);
    chk(memReq == 1'b0, "R1", "memReq after reset", 32'(memReq), 0);

    // R1 / R3 / R10: first read misses and fetches the aligned line
    snap();
    access(32'h0000_0004, 0, 1, 0);
    chk(lineReads == r0 + 1, "R1", "line read on first access", 32'(lineReads - r0), 1);
    chk(lastLineAddr == 32'h0, "R10", "refill address", lastLineAddr, 32'h0);

    // R2 / R10: same line, other word: hit, one-edge latency
    snap();
    access(32'h0000_0008, 0, 1, 0);
    noTraffic("R2");
    chk(lastLat == 1, "R2", "hit response latency", 32'(lastLat), 1);

    // R9: second tag in set 0 takes the free way; both stay resident
    access(32'h0000_0204, 0, 0, 0);
    snap();
    access(32'h0000_0000, 0, 1, 0);
    access(32'h0000_0200, 0, 0, 0);
    noTraffic("R9");

    // R4 / R8: copy-back write miss in a full set of clean lines
    snap();
    access(32'h0000_040C, 1, 1, 32'hDEAD_0001);
    chk(lineReads == r0 + 1, "R4", "refill on allocating write", 32'(lineReads - r0), 1);
    chk(lineWrites == w0 && wordWrites == ww0, "R8", "no write for clean victim",
        32'(lineWrites - w0 + wordWrites - ww0), 0);
    chk(mem[32'h40C >> 2] != 32'hDEAD_0001, "R4", "memory untouched", mem[32'h40C >> 2], 32'h0);

    // R5: copy-back write hit stays in the cache
    snap();
    access(32'h0000_0410, 1, 1, 32'hBEEF_0002);
    noTraffic("R5");
    chk(mem[32'h410 >> 2] != 32'hBEEF_0002, "R5", "memory keeps old value", mem[32'h410 >> 2], 32'h0);

    // R4: merged word read back as a hit
    snap();
    access(32'h0000_040C, 0, 1, 0);
    noTraffic("R4");

    // R6: pass-through write miss, then read of the same address misses
    snap();
    access(32'h0000_1004, 1, 0, 32'h1234_5678);
    chk(wordWrites == ww0 + 1, "R6", "single word write", 32'(wordWrites - ww0), 1);
    chk(lineReads == r0, "R6", "no refill on bypass write", 32'(lineReads - r0), 0);
    chk(lastWordEn == 8'b0000_0010, "R6", "word enable", 32'(lastWordEn), 32'h2);
    chk(mem[32'h1004 >> 2] == 32'h1234_5678, "R6", "memory word", mem[32'h1004 >> 2], 32'h1234_5678);
    snap();
    access(32'h0000_1004, 0, 0, 0);
    chk(lineReads == r0 + 1, "R6", "line not allocated", 32'(lineReads - r0), 1);

    // R7: pass-through write hit updates cache and memory, line stays clean
    access(32'h0000_00A0, 0, 0, 0);
    snap();
    access(32'h0000_00A4, 1, 0, 32'hCAFE_0007);
    chk(wordWrites == ww0 + 1 && lineReads == r0, "R7", "one word write on hit",
        32'(wordWrites - ww0), 1);
    chk(mem[32'hA4 >> 2] == 32'hCAFE_0007, "R7", "memory updated", mem[32'hA4 >> 2], 32'hCAFE_0007);
    snap();
    access(32'h0000_00A4, 0, 0, 0);
    noTraffic("R7");
    snap();
    for (int t = 1; t < 6; t++) access(32'(t * 32'h200 + 32'hA0), 0, 0, 0);
    chk(lineWrites == w0, "R7", "clean set never written back", 32'(lineWrites - w0), 0);

    // R8: mixed traffic over two conflict-heavy sets
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = 32'(($urandom % 6) * 32'h200 + ($urandom % 2) * 32'h20 + ($urandom % 8) * 4);
      access(a, 1'($urandom % 2), 1'($urandom % 2), $urandom);
    end
    chk(lineWrites > 0, "R8", "modified victims written back", 32'(lineWrites), 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule